// File: doc/BRIEF.md
# Write-Coalescing Byte Coverage Tracker

This block follows one outstanding miss entry the size of a cache line and records which bytes of that line the queued requests have written. When every byte is covered, the miss can go out as a full-line write that needs no data fetch from below. The block reports this coverage as a status bit.

Each added request carries a write flag, a byte offset, a byte size, eight attribute bits and four list flags. The block holds a per-byte coverage map, a merge-permitted bit, four sticky list flags and an "empty list" marker. Any request that is not a plain write with all attributes clear permanently stops merging. There is one exception: the first write into an empty list still marks its bytes. Once the line is fully covered, the map and the merge bit freeze.

When the miss is issued, a registered copy of the full-coverage bit is taken. That copy stays in place while later requests keep arriving. An init pulse returns the entry to its empty state.

Top module: `wrcov_tracker`

## Requirements
- R1: After reset or an init pulse, the coverage map is all zeros, merge-permitted is 1, full-line is 0, is-reset is 1 and the issued copy is 0.
- R2: A request is compatible only when its write flag is 1 and all eight attribute bits are 0. The attribute bits are: bit0 uncacheable, bit1 strictly ordered, bit2 internal-register access, bit3 privileged, bit4 linked load/conditional store, bit5 swap, bit6 conditional swap, bit7 secure.
- R3: On every added request, merge-permitted becomes its old value ANDed with that request's compatibility. Once it is 0 it stays 0 until init.
- R4: A write added to an empty list marks its bytes even when it is incompatible. A list counts as empty when no request of any kind has been added since init.
- R5: A compatible write sets the map bits from its offset for its size in bytes. Bits at or beyond the line end are dropped, and a size of 0 marks nothing.
- R6: A read, or an incompatible write that is not the first request, leaves the map unchanged.
- R7: While the whole line is covered, added requests change neither the map nor merge-permitted.
- R8: Full-line equals the AND of all map bits.
- R9: The needs-writable, upgrade, allocate-on-fill and from-cache flags are the OR of the matching request flags since init. Is-reset is 1 only when all four flags are 0 and merge-permitted is 1.
- R10: On an issue pulse, the issued copy loads the full-line value present before that edge. At all other times it holds, unless an init clears it.
- R11: An init in the same cycle as an add or an issue wins, and the entry ends in the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Return the entry to the empty state |
| add_valid_i | input | 1 | A request is added this cycle |
| add_write_i | input | 1 | Added request is a write |
| add_offset_i | input | OFS_W | Byte offset within the line |
| add_size_i | input | OFS_W+1 | Byte count, 0 to LINE_BYTES |
| add_attr_i | input | 8 | Attribute bits (see R2) |
| add_needs_wr_i | input | 1 | Request needs a writable copy |
| add_upgrade_i | input | 1 | Request is an upgrade |
| add_alloc_i | input | 1 | Request allocates on fill |
| add_from_cache_i | input | 1 | Request comes from another cache |
| issue_i | input | 1 | Miss is issued; capture full-line |
| cov_map_o | output | LINE_BYTES | Per-byte coverage map |
| can_merge_o | output | 1 | Merge-permitted bit |
| full_line_o | output | 1 | Whole line covered |
| is_reset_o | output | 1 | All list flags clear and merging permitted |
| issued_full_o | output | 1 | Full-line value captured at issue |

## Verification
The bench builds the block with its default 64-byte line. At that size a single request can cover the whole line, and writes with offsets near the end run past the line boundary, so both full coverage and clipping occur often. Fixed-seed random traffic is biased toward power-of-two sizes and mostly clear attributes. This bias lets random sequences reach full coverage and then carry on past it, which exercises the freeze behaviour. Directed sequences add the cases that random traffic hits too rarely: an incompatible first write, a read before a write, and init colliding with add and issue.

// File: rtl/wrcov_pkg.sv
package wrcov_pkg;
  localparam int ATTR_W = 8;
  // attribute bit positions
  localparam int A_UNCACHED = 0;
  localparam int A_STRICT   = 1;
  localparam int A_INTREG   = 2;
  localparam int A_PRIV     = 3;
  localparam int A_LLSC     = 4;
  localparam int A_SWAP     = 5;
  localparam int A_CSWAP    = 6;
  localparam int A_SECURE   = 7;

  typedef struct packed {
    logic needs_wr;
    logic upgrade;
    logic alloc;
    logic from_cache;
  } list_flags_t;

  function automatic logic merge_ok(input logic is_wr, input logic [ATTR_W-1:0] attr);
    logic blocked;
    blocked = attr[A_UNCACHED] | attr[A_STRICT] | attr[A_INTREG] | attr[A_PRIV] |
              attr[A_LLSC] | attr[A_SWAP] | attr[A_CSWAP] | attr[A_SECURE];
    return is_wr & ~blocked;
  endfunction
endpackage

// File: rtl/wrcov_classify.sv
module wrcov_classify
  import wrcov_pkg::*;
(
  input  logic              is_write_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic              list_empty_i,
  output logic              compat_o,
  output logic              first_wr_o
);
  always_comb begin
    compat_o   = merge_ok(is_write_i, attr_i);
    first_wr_o = is_write_i & list_empty_i;
  end
endmodule

// File: rtl/wrcov_bitmap.sv
module wrcov_bitmap #(
  parameter int LINE_BYTES = 64,
  localparam int OFS_W  = $clog2(LINE_BYTES),
  localparam int SIZE_W = OFS_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init_i,
  input  logic                  add_i,
  input  logic                  compat_i,
  input  logic                  first_wr_i,
  input  logic [OFS_W-1:0]      offset_i,
  input  logic [SIZE_W-1:0]     size_i,
  output logic [LINE_BYTES-1:0] map_o,
  output logic                  merge_o,
  output logic                  full_o,
  output logic                  mark_o
);
  localparam int SUM_W = SIZE_W + 1;

  // bytes [offset, offset+size) clipped at the line end
  function automatic logic [LINE_BYTES-1:0] span_mask(input logic [OFS_W-1:0] ofs,
                                                      input logic [SIZE_W-1:0] sz);
    logic [LINE_BYTES-1:0] m;
    logic [SUM_W-1:0] lo, hi;
    lo = SUM_W'(ofs);
    hi = SUM_W'(ofs) + SUM_W'(sz);
    for (int i = 0; i < LINE_BYTES; i++)
      m[i] = (SUM_W'(i) >= lo) && (SUM_W'(i) < hi);
    return m;
  endfunction

  logic [LINE_BYTES-1:0] map_q;
  logic                  merge_q;
  logic                  upd_en;

  assign full_o  = &map_q;
  assign upd_en  = add_i & ~full_o;
  assign mark_o  = upd_en & (first_wr_i | compat_i);
  assign map_o   = map_q;
  assign merge_o = merge_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q   <= '0;
      merge_q <= 1'b1;
    end else if (init_i) begin
      map_q   <= '0;
      merge_q <= 1'b1;
    end else if (upd_en) begin
      merge_q <= merge_q & compat_i;
      if (mark_o) map_q <= map_q | span_mask(offset_i, size_i);
    end
  end
endmodule

// File: rtl/wrcov_flags.sv
module wrcov_flags
  import wrcov_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_i,
  input  logic        add_i,
  input  list_flags_t req_flags_i,
  output list_flags_t flags_o,
  output logic        empty_o
);
  list_flags_t flags_q;
  logic        empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      empty_q <= 1'b1;
    end else if (init_i) begin
      flags_q <= '0;
      empty_q <= 1'b1;
    end else if (add_i) begin
      flags_q <= flags_q | req_flags_i;
      empty_q <= 1'b0;
    end
  end

  assign flags_o = flags_q;
  assign empty_o = empty_q;
endmodule

// File: rtl/wrcov_tracker.sv
module wrcov_tracker
  import wrcov_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  localparam int OFS_W  = $clog2(LINE_BYTES),
  localparam int SIZE_W = OFS_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init_i,
  input  logic                  add_valid_i,
  input  logic                  add_write_i,
  input  logic [OFS_W-1:0]      add_offset_i,
  input  logic [SIZE_W-1:0]     add_size_i,
  input  logic [ATTR_W-1:0]     add_attr_i,
  input  logic                  add_needs_wr_i,
  input  logic                  add_upgrade_i,
  input  logic                  add_alloc_i,
  input  logic                  add_from_cache_i,
  input  logic                  issue_i,
  output logic [LINE_BYTES-1:0] cov_map_o,
  output logic                  can_merge_o,
  output logic                  full_line_o,
  output logic                  is_reset_o,
  output logic                  issued_full_o
);
  logic        compat_w, first_wr_w, list_empty_w, mark_w;
  list_flags_t req_flags_w, flags_w;
  logic        issued_q;

  assign req_flags_w = '{needs_wr: add_needs_wr_i, upgrade: add_upgrade_i,
                         alloc: add_alloc_i, from_cache: add_from_cache_i};

  wrcov_classify u_cls (
    .is_write_i   (add_write_i),
    .attr_i       (add_attr_i),
    .list_empty_i (list_empty_w),
    .compat_o     (compat_w),
    .first_wr_o   (first_wr_w)
  );

  wrcov_bitmap #(.LINE_BYTES(LINE_BYTES)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init_i),
    .add_i      (add_valid_i),
    .compat_i   (compat_w),
    .first_wr_i (first_wr_w),
    .offset_i   (add_offset_i),
    .size_i     (add_size_i),
    .map_o      (cov_map_o),
    .merge_o    (can_merge_o),
    .full_o     (full_line_o),
    .mark_o     (mark_w)
  );

  wrcov_flags u_flg (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (init_i),
    .add_i       (add_valid_i),
    .req_flags_i (req_flags_w),
    .flags_o     (flags_w),
    .empty_o     (list_empty_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       issued_q <= 1'b0;
    else if (init_i)  issued_q <= 1'b0;
    else if (issue_i) issued_q <= full_line_o;
  end

  assign issued_full_o = issued_q;
  assign is_reset_o    = ~(|flags_w) & can_merge_o;
endmodule

// File: rtl/wrcov_chk.sv
module wrcov_chk #(
  parameter int LINE_BYTES = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  init_i,
  input logic                  add_valid_i,
  input logic                  issue_i,
  input logic                  mark_w,
  input logic [LINE_BYTES-1:0] cov_map_o,
  input logic                  can_merge_o,
  input logic                  full_line_o,
  input logic                  is_reset_o,
  input logic                  issued_full_o
);
  // R1
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (cov_map_o == '0) && can_merge_o && !issued_full_o);
  // R3
  merge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !can_merge_o) |=> !can_merge_o);
  // R6
  map_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_i |=> ((cov_map_o & $past(cov_map_o)) == $past(cov_map_o)));
  // R6
  no_mark_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !mark_w) |=> $stable(cov_map_o));
  // R7
  full_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && full_line_o) |=> $stable(cov_map_o) && $stable(can_merge_o));
  // R10
  issued_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !issue_i) |=> $stable(issued_full_o));
  // R10
  issued_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && issue_i) |=> (issued_full_o == $past(full_line_o)));
  // R9
  reset_needs_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_reset_o |-> can_merge_o);
  // R3
  idle_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !add_valid_i) |=> $stable(can_merge_o));
endmodule

bind wrcov_tracker wrcov_chk #(.LINE_BYTES(LINE_BYTES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .init_i        (init_i),
  .add_valid_i   (add_valid_i),
  .issue_i       (issue_i),
  .mark_w        (mark_w),
  .cov_map_o     (cov_map_o),
  .can_merge_o   (can_merge_o),
  .full_line_o   (full_line_o),
  .is_reset_o    (is_reset_o),
  .issued_full_o (issued_full_o)
);

// File: tb/wrcov_tracker_tb.sv
module wrcov_tracker_tb;
  localparam int LB = 64;
  localparam int OW = 6;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_i = 0, add_valid_i = 0, add_write_i = 0, issue_i = 0;
  logic [OW-1:0] add_offset_i = '0;
  logic [OW:0]   add_size_i = '0;
  logic [7:0]    add_attr_i = '0;
  logic nw_i = 0, up_i = 0, al_i = 0, fc_i = 0;
  logic [LB-1:0] cov_map_o;
  logic can_merge_o, full_line_o, is_reset_o, issued_full_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [LB-1:0] m_map;
  logic m_merge, m_empty, m_iss;
  logic [3:0] m_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrcov_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .add_valid_i(add_valid_i),
    .add_write_i(add_write_i), .add_offset_i(add_offset_i), .add_size_i(add_size_i),
    .add_attr_i(add_attr_i), .add_needs_wr_i(nw_i), .add_upgrade_i(up_i),
    .add_alloc_i(al_i), .add_from_cache_i(fc_i), .issue_i(issue_i),
    .cov_map_o(cov_map_o), .can_merge_o(can_merge_o), .full_line_o(full_line_o),
    .is_reset_o(is_reset_o), .issued_full_o(issued_full_o)
  );

  function automatic logic [LB-1:0] span(input int ofs, input int sz);
    logic [LB-1:0] r = '0;
    for (int b = ofs; b < ofs + sz && b < LB; b++) r[b] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string req, input logic [LB-1:0] act, input logic [LB-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_init();
    m_map = '0; m_merge = 1; m_empty = 1; m_iss = 0; m_flags = '0;
  endtask

  task automatic compare_all();
    chk("R5 map", cov_map_o, m_map);
    chk("R3 merge", LB'(can_merge_o), LB'(m_merge));
    chk("R8 full", LB'(full_line_o), LB'(&m_map));
    chk("R9 is_reset", LB'(is_reset_o), LB'(m_merge && m_flags == 0));
    chk("R10 issued", LB'(issued_full_o), LB'(m_iss));
  endtask

  // one cycle: drive at negedge, update model, compare at next negedge
  task automatic step(input bit ini, input bit add, input bit wr, input int ofs,
                      input int sz, input logic [7:0] attr, input logic [3:0] fl,
                      input bit iss);
    logic compat;
    init_i = ini; add_valid_i = add; add_write_i = wr;
    add_offset_i = OW'(ofs); add_size_i = (OW+1)'(sz); add_attr_i = attr;
    {nw_i, up_i, al_i, fc_i} = fl; issue_i = iss;
    compat = wr && (attr == 8'h00);  // R2
    if (ini) model_init();            // R11
    else begin
      if (iss) m_iss = &m_map;
      if (add) begin
        if (!(&m_map)) begin
          m_merge = m_merge & compat;
          if ((wr && m_empty) || compat) m_map = m_map | span(ofs, sz);
        end
        m_flags = m_flags | fl;
        m_empty = 0;
      end
    end
    @(negedge clk);
    init_i = 0; add_valid_i = 0; issue_i = 0;
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_init();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    compare_all();
    chk("R1 reset is_reset", LB'(is_reset_o), LB'(1));

    // R4: secure first write covers line and marks
    step(0, 1, 1, 0, 64, 8'h80, 4'h0, 0);
    chk("R4 incompatible first write marks", cov_map_o, '1);
    chk("R2 secure clears merge", LB'(can_merge_o), LB'(0));
    // R7 after full, further write leaves state, R10 capture
    step(0, 1, 1, 3, 4, 8'h00, 4'h0, 1);
    chk("R10 issued full captured", LB'(issued_full_o), LB'(1));
    // R11 init with add and issue
    step(1, 1, 1, 0, 8, 8'h00, 4'hF, 1);
    chk("R11 init wins map", cov_map_o, '0);
    chk("R11 init wins flags", LB'(is_reset_o), LB'(1));

    // R6: read first, then incompatible write does not mark
    step(0, 1, 0, 0, 16, 8'h00, 4'h2, 0);
    step(0, 1, 1, 0, 16, 8'h10, 4'h0, 0);
    chk("R6 incompatible non-first write ignored", cov_map_o, '0);
    // R5 clipping at line end
    step(1, 0, 0, 0, 0, 8'h00, 4'h0, 0);
    step(0, 1, 1, 60, 16, 8'h00, 4'h0, 0);
    chk("R5 clipped span", cov_map_o, span(60, 4));
    step(0, 1, 1, 10, 0, 8'h00, 4'h0, 0);
    chk("R5 size zero", cov_map_o, span(60, 4));
    // R10 issue while partial, then complete: copy stays 0
    step(0, 0, 0, 0, 0, 8'h00, 4'h0, 1);
    step(0, 1, 1, 0, 60, 8'h00, 4'h0, 0);
    chk("R8 full after completion", LB'(full_line_o), LB'(1));
    chk("R10 copy unchanged after issue", LB'(issued_full_o), LB'(0));
    // R7: incompatible after full keeps merge
    step(0, 1, 1, 0, 4, 8'h01, 4'h0, 0);
    chk("R7 merge frozen when full", LB'(can_merge_o), LB'(1));

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int sz, ofs, pick;
      logic [7:0] at;
      pick = $urandom_range(0, 6);
      sz = (pick == 6) ? $urandom_range(0, 64) : (1 << pick);
      ofs = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 63) : (($urandom_range(0, 63) / sz) * sz) % 64;
      at = ($urandom_range(0, 9) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
      step($urandom_range(0, 14) == 0, $urandom_range(0, 3) != 0,
           $urandom_range(0, 5) != 0, ofs, sz, at,
           ($urandom_range(0, 7) == 0) ? 4'($urandom_range(1, 15)) : 4'h0,
           $urandom_range(0, 9) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule